// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block is a clocked stand-in for a 16-bit static RAM that has an asynchronous pin interface. A fast oversampling clock registers the five active-low control pins (chip select, write strobe, output strobe, upper byte select, lower byte select), the address and the incoming data. The block decodes the registered pins into one of four modes and drives each byte lane's output enable separately. It also reports whether the emulated part is drawing standby or active power.

A write is the overlap of chip select low, write strobe low and a lane's byte select low. The block tracks that overlap for each lane on its own. It registers address and data on every clock while the lane's window is open. When the window closes, whichever signal closes it, the last registered value goes into the array. The array depth is a parameter and is small by default. Address bits above the depth are ignored.

The data pins are split into an input bus, an output bus and a per-lane enable pair. A pad ring or a bench combines them into a tri-state bus.

Top module: `bytelane_sram_emu`

## Requirements
- R1: With chip select high, `mode_o` is 2'b00 (standby), `active_o` is 0, both lanes of `dq_oe_o` are 0, and no array location changes, whatever the other pins do.
- R2: With chip select low and both byte selects high, `mode_o` is 2'b00, `active_o` is 0, `dq_oe_o` is 2'b00 and nothing is stored.
- R3: With chip select low, write strobe high and output strobe low, `mode_o` is 2'b10. `dq_oe_o[0]` (bits 7:0) is 1 only if the lower select is low, and `dq_oe_o[1]` (bits 15:8) is 1 only if the upper select is low. Each driven lane carries the stored byte at the address.
- R4: With chip select low, write strobe high, output strobe high and at least one byte select low, `mode_o` is 2'b01, `dq_oe_o` is 2'b00 and `active_o` is 1.
- R5: With chip select and write strobe low and at least one byte select low, `mode_o` is 2'b11 and `dq_oe_o` is 2'b00 even when output strobe is low.
- R6: A write stores only the lanes whose byte select was low. The other lane keeps its earlier content.
- R7: When write strobe rises to end a write, the array receives the data and address last presented while the window was open. Earlier values in the same window are overwritten.
- R8: When chip select rises while write strobe is still low, the write ends and commits in the same way as R7.
- R9: Each lane's window is the overlap of chip select, write strobe and that lane's select. If one lane's select rises, that lane commits its last value while the other lane's window stays open and keeps capturing.
- R10: Only the low log2(DEPTH) address bits select a word. Addresses that differ only above those bits reach the same word.
- R11: During and right after reset, `mode_o` is 2'b00, `dq_oe_o` is 2'b00 and `active_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output strobe, active low |
| ub_n_i | input | 1 | Upper byte select (bits 15:8), active low |
| lb_n_i | input | 1 | Lower byte select (bits 7:0), active low |
| addr_i | input | AW_PINS | Word address pins |
| dq_i | input | 16 | Data arriving on the pins |
| dq_o | output | 16 | Read data per lane (zero when the lane is not driven) |
| dq_oe_o | output | 2 | Per-lane drive enable: bit 0 for 7:0, bit 1 for 15:8 |
| mode_o | output | 2 | 00 standby, 01 outputs off, 10 read, 11 write |
| active_o | output | 1 | 1 for active power, 0 for standby |

## Verification
Each pin pattern sits behind one sampling register. Mode, lane enables, the power flag and read data are therefore due on the first rising edge after the pins change. A commit reaches the array on the edge after the sample that shows the window closed, which is in time for a read presented in the very next cycle. The bench applies pins on the falling edge and queues the expected result. The monitor compares it 2 ns after the following rising edge. This keeps every comparison one edge behind its stimulus and leaves closing-step reads of the same word showing the old content.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned DATA_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'b00,
    MODE_OUTOFF  = 2'b01,
    MODE_READ    = 2'b10,
    MODE_WRITE   = 2'b11
  } emu_mode_e;

endpackage

// File: rtl/sram_emu_sampler.sv
module sram_emu_sampler #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [LANES-1:0]  be_n_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              cs_n_q,
  output logic              we_n_q,
  output logic              oe_n_q,
  output logic [LANES-1:0]  be_n_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] dq_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      be_n_q <= '1;
      idx_q  <= '0;
      dq_q   <= '0;
    end else begin
      cs_n_q <= cs_n_i;
      we_n_q <= we_n_i;
      oe_n_q <= oe_n_i;
      be_n_q <= be_n_i;
      idx_q  <= idx_i;
      dq_q   <= dq_i;
    end
  end

endmodule

// File: rtl/sram_emu_decoder.sv
module sram_emu_decoder
  import sram_emu_pkg::*;
#(
  parameter int unsigned NLANES = 2
) (
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [NLANES-1:0] be_n,
  output emu_mode_e         mode,
  output logic              active,
  output logic [NLANES-1:0] rd_lane,
  output logic [NLANES-1:0] wr_lane
);

  logic standby;

  always_comb begin
    standby = cs_n | (&be_n);
    active  = ~standby;
    if (standby)      mode = MODE_STANDBY;
    else if (!we_n)   mode = MODE_WRITE;
    else if (!oe_n)   mode = MODE_READ;
    else              mode = MODE_OUTOFF;
  end

  for (genvar l = 0; l < NLANES; l++) begin : g_lane_ctl
    always_comb begin
      rd_lane[l] = ~cs_n & we_n & ~oe_n & ~be_n[l];
      wr_lane[l] = ~cs_n & ~we_n & ~be_n[l];
    end
  end

endmodule

// File: rtl/sram_emu_lane.sv
module sram_emu_lane #(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_open_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANE_W-1:0] din_i,
  output logic [LANE_W-1:0] dout_o,
  output logic              commit_o
);

  logic              open_q;
  logic [IDX_W-1:0]  cap_idx_q, cap_idx_d;
  logic [LANE_W-1:0] cap_dat_q, cap_dat_d;
  logic [LANE_W-1:0] store [DEPTH];

  always_comb begin
    commit_o  = open_q & ~wr_open_i;
    cap_idx_d = cap_idx_q;
    cap_dat_d = cap_dat_q;
    if (wr_open_i) begin
      cap_idx_d = idx_i;
      cap_dat_d = din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      cap_idx_q <= '0;
      cap_dat_q <= '0;
    end else begin
      open_q    <= wr_open_i;
      cap_idx_q <= cap_idx_d;
      cap_dat_q <= cap_dat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (commit_o) begin
      store[cap_idx_q] <= cap_dat_q;
    end
  end

  assign dout_o = rd_en_i ? store[idx_i] : '0;

endmodule

// File: rtl/bytelane_sram_emu.sv
module bytelane_sram_emu
  import sram_emu_pkg::*;
#(
  parameter int unsigned AW_PINS = 18,
  parameter int unsigned DEPTH   = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_i,
  input  logic               we_n_i,
  input  logic               oe_n_i,
  input  logic               ub_n_i,
  input  logic               lb_n_i,
  input  logic [AW_PINS-1:0] addr_i,
  input  logic [15:0]        dq_i,
  output logic [15:0]        dq_o,
  output logic [1:0]         dq_oe_o,
  output logic [1:0]         mode_o,
  output logic               active_o
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic              s_cs_n, s_we_n, s_oe_n;
  logic [LANES-1:0]  s_be_n;
  logic [IDX_W-1:0]  s_idx;
  logic [DATA_W-1:0] s_dq;
  emu_mode_e         mode;
  logic [LANES-1:0]  rd_lane, wr_lane, commit;

  if (AW_PINS > IDX_W) begin : g_addr_hi
    logic unused_addr_hi;
    assign unused_addr_hi = ^addr_i[AW_PINS-1:IDX_W];
  end

  sram_emu_sampler #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n_i(cs_n_i),
    .we_n_i(we_n_i),
    .oe_n_i(oe_n_i),
    .be_n_i({ub_n_i, lb_n_i}),
    .idx_i (addr_i[IDX_W-1:0]),
    .dq_i  (dq_i),
    .cs_n_q(s_cs_n),
    .we_n_q(s_we_n),
    .oe_n_q(s_oe_n),
    .be_n_q(s_be_n),
    .idx_q (s_idx),
    .dq_q  (s_dq)
  );

  sram_emu_decoder #(
    .NLANES(LANES)
  ) u_decoder (
    .cs_n   (s_cs_n),
    .we_n   (s_we_n),
    .oe_n   (s_oe_n),
    .be_n   (s_be_n),
    .mode   (mode),
    .active (active_o),
    .rd_lane(rd_lane),
    .wr_lane(wr_lane)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_emu_lane #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W),
      .LANE_W(LANE_W)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_open_i(wr_lane[l]),
      .rd_en_i  (rd_lane[l]),
      .idx_i    (s_idx),
      .din_i    (s_dq[l*LANE_W +: LANE_W]),
      .dout_o   (dq_o[l*LANE_W +: LANE_W]),
      .commit_o (commit[l])
    );
  end

  assign dq_oe_o = rd_lane;
  assign mode_o  = mode;

  // R1, R2: standby never drives and reports standby power
  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_STANDBY) |-> (dq_oe_o == 2'b00 && !active_o));

  // R3: any driven lane implies read mode
  a_r3_drive_only_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe_o) |-> (mode_o == MODE_READ));

  // R4: outputs-off mode is active power and undriven
  a_r4_outoff_active: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_OUTOFF) |-> (active_o && dq_oe_o == 2'b00));

  // R5: a write never drives the pins
  a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_WRITE) |-> (dq_oe_o == 2'b00));

  // R6: an array commit only follows a cycle in write mode
  a_r6_commit_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit) |-> ($past(mode_o) == MODE_WRITE));

endmodule

// File: tb/test_bytelane_sram_emu.sv
module test_bytelane_sram_emu;

  localparam int AW    = 18;
  localparam int DEPTH = 1024;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, we_n, oe_n, ub_n, lb_n;
  logic [AW-1:0] addr;
  logic [15:0]   dq_in;
  logic [15:0]   dq_o;
  logic [1:0]    dq_oe;
  logic [1:0]    mode;
  logic          active;

  always #4 clk = ~clk;

  bytelane_sram_emu #(.AW_PINS(AW), .DEPTH(DEPTH)) i_bytelane_sram_emu (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .ub_n_i(ub_n), .lb_n_i(lb_n), .addr_i(addr), .dq_i(dq_in),
    .dq_o(dq_o), .dq_oe_o(dq_oe), .mode_o(mode), .active_o(active)
  );

  typedef struct {
    string      tag;
    logic [1:0] mode;
    logic [1:0] oe;
    logic       act;
    logic [1:0] chk;
    logic [15:0] dat;
  } exp_t;

  exp_t q[$];
  int   compared = 0;
  int   mismatched = 0;
  bit   done = 0;

  logic [7:0] mdl   [2][DEPTH];
  bit         known [2][DEPTH];
  bit         was_open [2];
  logic [9:0] cap_idx [2];
  logic [7:0] cap_dat [2];

  task automatic step(input string tag, input logic c, input logic w, input logic o,
                      input logic u, input logic lo, input logic [AW-1:0] a,
                      input logic [15:0] d);
    exp_t e;
    logic [1:0] be;
    logic [9:0] ix;
    bit sb;
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; ub_n = u; lb_n = lo; addr = a; dq_in = d;
    be = {u, lo};
    ix = a[9:0];
    sb = c | (u & lo);
    e.tag  = tag;
    e.act  = !sb;
    e.mode = sb ? 2'b00 : (!w ? 2'b11 : (!o ? 2'b10 : 2'b01));
    e.chk  = 2'b00;
    e.dat  = 16'h0;
    for (int l = 0; l < 2; l++) begin
      e.oe[l] = !c && w && !o && !be[l];
      if (e.oe[l] && known[l][ix]) begin
        e.chk[l] = 1'b1;
        e.dat[l*8 +: 8] = mdl[l][ix];
      end
    end
    q.push_back(e);
    for (int l = 0; l < 2; l++) begin
      if (!c && !w && !be[l]) begin
        cap_idx[l] = ix;
        cap_dat[l] = d[l*8 +: 8];
        was_open[l] = 1'b1;
      end else if (was_open[l]) begin
        mdl[l][cap_idx[l]]   = cap_dat[l];
        known[l][cap_idx[l]] = 1'b1;
        was_open[l] = 1'b0;
      end
    end
  endtask

  // monitor: compares one queued item 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        compared++;
        bad = 0;
        if (mode !== e.mode) begin
          $display("FAIL %s mode actual=%b expected=%b", e.tag, mode, e.mode); bad = 1;
        end
        if (dq_oe !== e.oe) begin
          $display("FAIL %s dq_oe actual=%b expected=%b", e.tag, dq_oe, e.oe); bad = 1;
        end
        if (active !== e.act) begin
          $display("FAIL %s active actual=%b expected=%b", e.tag, active, e.act); bad = 1;
        end
        for (int l = 0; l < 2; l++) begin
          if (e.chk[l] && dq_o[l*8 +: 8] !== e.dat[l*8 +: 8]) begin
            $display("FAIL %s lane%0d data actual=%h expected=%h", e.tag, l,
                     dq_o[l*8 +: 8], e.dat[l*8 +: 8]);
            bad = 1;
          end
        end
        if (bad) mismatched++;
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 2; l++) begin
      was_open[l] = 0;
      for (int i = 0; i < DEPTH; i++) begin
        known[l][i] = 0;
        mdl[l][i] = 8'h00;
      end
    end
    rst_n = 0; cs_n = 1; we_n = 1; oe_n = 1; ub_n = 1; lb_n = 1; addr = '0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compared++;
    if (mode !== 2'b00 || dq_oe !== 2'b00 || active !== 1'b0) begin
      mismatched++;
      $display("FAIL R11 in reset actual=%b/%b/%b expected=00/00/0", mode, dq_oe, active);
    end
    rst_n = 1;
    step("R11 after reset", 1, 1, 1, 1, 1, 18'h0, 16'h0);

    // R7: write word 3, data changes mid-window, write strobe ends it
    step("R5 write open",   0, 0, 1, 0, 0, 18'd3, 16'h1111);
    step("R7 write update", 0, 0, 1, 0, 0, 18'd3, 16'hA5C3);
    step("R4 close to outoff", 0, 1, 1, 0, 0, 18'd3, 16'h9999);
    step("R7 read back",    0, 1, 0, 0, 0, 18'd3, 16'h0);

    // R1: chip select high ignores a write attempt
    step("R1 deselected write", 1, 0, 0, 0, 0, 18'd3, 16'hFFFF);
    step("R1 idle",             1, 1, 1, 0, 0, 18'd3, 16'hFFFF);
    step("R1 no store check",   0, 1, 0, 0, 0, 18'd3, 16'h0);

    // R2: both selects high, write strobe low
    step("R2 both lanes off", 0, 0, 0, 1, 1, 18'd3, 16'h0000);
    step("R2 idle",           0, 1, 1, 1, 1, 18'd3, 16'h0000);
    step("R2 no store check", 0, 1, 0, 0, 0, 18'd3, 16'h0);

    // R5, R8: write with output strobe low, chip select ends it
    step("R5 write oe low", 0, 0, 0, 0, 0, 18'd7, 16'h1234);
    step("R8 cs ends",      1, 0, 0, 0, 0, 18'd7, 16'hEEEE);
    step("R8 read back",    0, 1, 0, 0, 0, 18'd7, 16'h0);

    // R6, R9: upper lane only, ended by its select rising
    step("R6 upper only",  0, 0, 1, 0, 1, 18'd7, 16'hBEEF);
    step("R9 select ends", 0, 0, 1, 1, 1, 18'd7, 16'h0000);
    step("R6 read both",   0, 1, 0, 0, 0, 18'd7, 16'h0);
    step("R3 read low lane",  0, 1, 0, 1, 0, 18'd7, 16'h0);
    step("R3 read high lane", 0, 1, 0, 0, 1, 18'd7, 16'h0);

    // R9: lanes close at different times
    step("R9 both open",   0, 0, 1, 0, 0, 18'd9, 16'h5566);
    step("R9 upper closes",0, 0, 1, 1, 0, 18'd9, 16'h7788);
    step("R9 lower closes",0, 1, 1, 1, 0, 18'd9, 16'h0000);
    step("R9 read back",   0, 1, 0, 0, 0, 18'd9, 16'h0);

    // R10: high address bits alias
    step("R10 write high addr", 0, 0, 1, 0, 0, 18'h20405, 16'hCAFE);
    step("R10 close",           0, 1, 1, 0, 0, 18'h20405, 16'h0);
    step("R10 read alias a",    0, 1, 0, 0, 0, 18'h00005, 16'h0);
    step("R10 read alias b",    0, 1, 0, 0, 0, 18'h00405, 16'h0);

    // R4 with single lane selected, then return to standby
    step("R4 outoff one lane", 0, 1, 1, 1, 0, 18'd9, 16'h0);
    step("R1 back to standby", 1, 1, 0, 0, 0, 18'd9, 16'h0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule